// File: doc/BRIEF.md
# I2C Target GPIO Port Expander

This block is an I2C target that owns an 8-bit general-purpose I/O port. A bus master reaches four byte-wide registers through it: a live view of the pin levels, the output values, a per-pin polarity inversion mask and a per-pin direction mask. The block samples SCL and SDA with its own system clock and finds START and STOP conditions from the sampled levels. It answers only to a 7-bit address that is fixed by a parameter.

A write transaction carries the address, then a command byte that selects one of the four registers, then any number of data bytes. Every data byte lands in the selected register. A read returns the selected register and keeps returning it for as long as the master acknowledges. The pointer survives a repeated START, so the usual sequence of writing a command and then issuing a repeated START and a read returns the chosen register.

SDA is open-drain. The block reports the pull-down as a separate drive-low output, and the integrator combines it with the pad. On the port side the block provides output values and active-high output enables, and it takes the pin levels as an input.

Top module: `i2c_gpio_expander`

## Requirements
- R1: After a START and an address byte whose upper seven bits equal `DEV_ADDR`, the block asserts `sda_low_o` from the SCL fall after the eighth bit until the SCL fall after the ninth bit. SDA is therefore low for the entire high phase of the ninth clock. Bit 0 of the address byte is 1 for a read and 0 for a write.
- R2: In a write transaction the block acknowledges every byte it receives after the address, including writes to the read-only register.
- R3: The first byte after a write address is the command. Its low two bits select the register: 0 is the pin input view, 1 is the output values, 2 is the polarity mask and 3 is the direction mask. Every later data byte in the same transaction is written to that same register.
- R4: A read shifts the selected register out MSB first, with SDA changing only while SCL is low. After a master acknowledge the block sends the selected register again.
- R5: If the master does not acknowledge a read byte, the block drives SDA no further and ignores all bytes until the next STOP or START.
- R6: Reading register 0 returns the synchronised pin levels XOR the polarity mask, whatever the direction of each pin. Data written to register 0 is discarded and changes no register.
- R7: After reset the output values are 0xFF, the polarity mask is 0x00 and the direction mask is 0xFF, and `sda_low_o` is low.
- R8: `pin_out_o` equals the output-value register. `pin_oe_o` is the bitwise inverse of the direction mask, so a direction bit of 1 makes the pin an input.
- R9: A repeated START keeps the stored pointer. A read that follows without a new command returns the register chosen last.
- R10: An address byte that does not match gets no acknowledge, and the block ignores the bus until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line (wired AND of all drivers) |
| sda_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| pin_in_i | input | 8 | Pad levels of the I/O pins |
| pin_out_o | output | 8 | Value to drive on each pin |
| pin_oe_o | output | 8 | Per-pin output enable, active high |

## Verification
The assertions assume that SCL changes slowly compared with `clk`. Each SCL phase must last longer than the synchroniser latency plus one cycle, so the block's SDA updates after a sampled SCL fall settle before the next rise. They also assume that the master changes SDA only while SCL is low, except when it makes a START or STOP, and that no START or STOP arrives while the block drives SDA. The bench holds each SCL phase for eight clocks and moves its own SDA two clocks after a fall. It creates START and STOP only with SDA released by the block, and it keeps the pin inputs constant during each read.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int BYTE_W = 8;
   localparam int SEL_W  = 2;

   typedef logic [SEL_W-1:0] gpx_sel_t;

   localparam gpx_sel_t SEL_IN  = 2'd0;
   localparam gpx_sel_t SEL_OUT = 2'd1;
   localparam gpx_sel_t SEL_POL = 2'd2;
   localparam gpx_sel_t SEL_DIR = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_RX,
      ST_TX,
      ST_TXACK,
      ST_IGNORE
   } gpx_state_t;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int            W       = 2,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
   import gpx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  gpx_sel_t          wr_sel_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  gpx_sel_t          rd_sel_i,
   input  logic [BYTE_W-1:0] pin_lvl_i,
   output logic [BYTE_W-1:0] rd_data_o,
   output logic [BYTE_W-1:0] out_q_o,
   output logic [BYTE_W-1:0] dir_q_o
);
   logic [BYTE_W-1:0] out_q, pol_q, dir_q;
   logic [BYTE_W-1:0] in_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '1;
         pol_q <= '0;
         dir_q <= '1;
      end else if (wr_en_i) begin
         case (wr_sel_i)
            SEL_OUT: out_q <= wr_data_i;
            SEL_POL: pol_q <= wr_data_i;
            SEL_DIR: dir_q <= wr_data_i;
            default: ;
         endcase
      end
   end

   assign in_view = pin_lvl_i ^ pol_q;

   always_comb begin
      case (rd_sel_i)
         SEL_IN:  rd_data_o = in_view;
         SEL_OUT: rd_data_o = out_q;
         SEL_POL: rd_data_o = pol_q;
         default: rd_data_o = dir_q;
      endcase
   end

   assign out_q_o = out_q;
   assign dir_q_o = dir_q;

   // R7
   reset_val_chk: assert property (@(posedge clk)
      !rst_n |=> (out_q == 8'hFF && pol_q == 8'h00 && dir_q == 8'hFF));

   // R6
   input_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i == SEL_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));
endmodule

// File: rtl/gpx_bus.sv
module gpx_bus
   import gpx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s_i,
   input  logic              sda_s_i,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic              wr_en_o,
   output gpx_sel_t          wr_sel_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output gpx_sel_t          rd_sel_o,
   output logic              sda_low_o
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   gpx_state_t        state_q;
   logic              scl_q, sda_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] rx_sh_q, tx_sh_q;
   logic              rd_mode_q, cmd_next_q, mack_q;
   gpx_sel_t          ptr_q;
   logic              scl_rise, scl_fall, start_c, stop_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s_i;
         sda_q <= sda_s_i;
      end
   end

   assign scl_rise = scl_s_i & ~scl_q;
   assign scl_fall = ~scl_s_i & scl_q;
   assign start_c  = scl_s_i & scl_q & sda_q & ~sda_s_i;
   assign stop_c   = scl_s_i & scl_q & ~sda_q & sda_s_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         rx_sh_q    <= '0;
         tx_sh_q    <= '1;
         rd_mode_q  <= 1'b0;
         cmd_next_q <= 1'b0;
         mack_q     <= 1'b0;
         ptr_q      <= SEL_IN;
         wr_en_o    <= 1'b0;
         wr_data_o  <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_c) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
         end else if (stop_c) begin
            state_q <= ST_IDLE;
         end else begin
            case (state_q)
               ST_ADDR, ST_RX: begin
                  if (scl_rise) begin
                     rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sda_s_i};
                     cnt_q   <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == CNT_FULL) begin
                     cnt_q <= '0;
                     if (state_q == ST_ADDR) begin
                        if (rx_sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                           state_q    <= ST_ACK;
                           rd_mode_q  <= rx_sh_q[0];
                           cmd_next_q <= ~rx_sh_q[0];
                        end else begin
                           state_q <= ST_IGNORE;
                        end
                     end else begin
                        state_q <= ST_ACK;
                        if (cmd_next_q) begin
                           ptr_q      <= rx_sh_q[SEL_W-1:0];
                           cmd_next_q <= 1'b0;
                        end else begin
                           wr_en_o   <= 1'b1;
                           wr_data_o <= rx_sh_q;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt_q <= '0;
                     if (rd_mode_q) begin
                        state_q <= ST_TX;
                        tx_sh_q <= rd_data_i;
                     end else begin
                        state_q <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt_q == CNT_LAST) begin
                        state_q <= ST_TXACK;
                     end else begin
                        tx_sh_q <= {tx_sh_q[BYTE_W-2:0], 1'b1};
                        cnt_q   <= cnt_q + 1'b1;
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s_i;
                  end else if (scl_fall) begin
                     cnt_q <= '0;
                     if (mack_q) begin
                        state_q <= ST_TX;
                        tx_sh_q <= rd_data_i;
                     end else begin
                        state_q <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_low_o = (state_q == ST_ACK) | ((state_q == ST_TX) & ~tx_sh_q[BYTE_W-1]);
   assign wr_sel_o  = ptr_q;
   assign rd_sel_o  = ptr_q;

   // R1
   ack_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACK && scl_s_i && scl_q && !start_c && !stop_c) |=> sda_low_o);

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s_i && scl_q && !start_c && !stop_c) |=> $stable(sda_low_o));

   // R5
   ign_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IGNORE) |=> (state_q == ST_IGNORE || state_q == ST_ADDR || state_q == ST_IDLE));
endmodule

// File: rtl/i2c_gpio_expander.sv
module i2c_gpio_expander
   import gpx_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h24,
   parameter int         PORT_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter bit         PIN_SYNC    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_low_o,
   input  logic [PORT_W-1:0] pin_in_i,
   output logic [PORT_W-1:0] pin_out_o,
   output logic [PORT_W-1:0] pin_oe_o
);
   generate
      if (PORT_W != BYTE_W) begin : g_bad_width
         $error("PORT_W must equal the register byte width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [1:0]        bus_s;
   logic [BYTE_W-1:0] pin_lvl, rd_data, out_q, dir_q, wr_data;
   logic              wr_en;
   gpx_sel_t          wr_sel, rd_sel;

   gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk (clk), .rst_n (rst_n), .d_i ({scl_i, sda_i}), .q_o (bus_s)
   );

   generate
      if (PIN_SYNC) begin : g_pin_sync
         gpx_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_pin_sync (
            .clk (clk), .rst_n (rst_n), .d_i (pin_in_i), .q_o (pin_lvl)
         );
      end else begin : g_pin_direct
         assign pin_lvl = pin_in_i;
      end
   endgenerate

   gpx_bus #(.DEV_ADDR(DEV_ADDR)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s_i   (bus_s[1]),
      .sda_s_i   (bus_s[0]),
      .rd_data_i (rd_data),
      .wr_en_o   (wr_en),
      .wr_sel_o  (wr_sel),
      .wr_data_o (wr_data),
      .rd_sel_o  (rd_sel),
      .sda_low_o (sda_low_o)
   );

   gpx_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .rd_sel_i  (rd_sel),
      .pin_lvl_i (pin_lvl),
      .rd_data_o (rd_data),
      .out_q_o   (out_q),
      .dir_q_o   (dir_q)
   );

   assign pin_out_o = out_q;
   assign pin_oe_o  = ~dir_q;
endmodule

// File: tb/i2c_gpio_expander_bench.sv
module i2c_gpio_expander_bench;
   localparam logic [6:0] ADDR = 7'h24;
   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [7:0] pins = 8'hFF;
   logic       sda_low;
   logic [7:0] pin_out, pin_oe;
   wire        sda_line = sda_m & ~sda_low;

   int n_chk = 0;
   int n_fail = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   logic [7:0] m_out = 8'hFF, m_pol = 8'h00, m_dir = 8'hFF;

   always #5 clk = ~clk;

   i2c_gpio_expander #(.DEV_ADDR(ADDR)) u_i2c_gpio_expander (
      .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_line),
      .sda_low_o (sda_low), .pin_in_i (pins), .pin_out_o (pin_out), .pin_oe_o (pin_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // reference comparison on every clock while the bus is idle
   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R8 out", pin_out, m_out);
         chk("R8 oe", pin_oe, ~m_dir);
         chk("R5 idle sda", {7'b0, sda_low}, 8'h00);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start;
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(2);
   endtask

   // returns 1 only if the line is low at both ends of the high phase
   task automatic recv_bit(output logic b, output logic low_all);
      logic first;
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(1);
      first = sda_line;
      tick(H - 2);
      b = sda_line;
      low_all = !first && !b;
      tick(1);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic ack);
      logic b, lo;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(b, lo);
      ack = lo;
   endtask

   task automatic get_byte(input logic mack, output logic [7:0] v);
      logic b, lo;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b, lo);
         v[i] = b;
      end
      send_bit(~mack);
   endtask

   function automatic logic [7:0] exp_reg(input int sel);
      case (sel)
         0: return pins ^ m_pol;
         1: return m_out;
         2: return m_pol;
         default: return m_dir;
      endcase
   endfunction

   task automatic model_write(input int sel, input logic [7:0] v);
      case (sel)
         1: m_out = v;
         2: m_pol = v;
         3: m_dir = v;
         default: ;
      endcase
   endtask

   // single-register write of one byte with ack checks
   task automatic wr_reg(input int sel, input logic [7:0] v);
      logic a;
      cmp_en = 1'b0;
      bus_start;
      put_byte({ADDR, 1'b0}, a); chk("R1 addr ack", {7'b0, a}, 8'h01);
      put_byte(8'(sel), a);      chk("R2 cmd ack", {7'b0, a}, 8'h01);
      put_byte(v, a);            chk("R2 data ack", {7'b0, a}, 8'h01);
      bus_stop;
      model_write(sel, v);
      tick(2);
      cmp_en = 1'b1;
   endtask

   // command, repeated start, read of n bytes (last not acknowledged)
   task automatic rd_reg(input int sel, input int n, input string req);
      logic a;
      logic [7:0] v;
      cmp_en = 1'b0;
      bus_start;
      put_byte({ADDR, 1'b0}, a); chk("R1 addr ack", {7'b0, a}, 8'h01);
      put_byte(8'(sel), a);      chk("R2 cmd ack", {7'b0, a}, 8'h01);
      bus_start;
      put_byte({ADDR, 1'b1}, a); chk("R9 read addr ack", {7'b0, a}, 8'h01);
      for (int k = 0; k < n; k++) begin
         get_byte(k != n - 1, v);
         chk(req, v, exp_reg(sel));
      end
      bus_stop;
      tick(2);
      cmp_en = 1'b1;
   endtask

   initial begin
      logic a;
      logic [7:0] v;
      tick(5);
      // R7 reset state, sampled while reset is held
      chk("R7 out reset", pin_out, 8'hFF);
      chk("R7 oe reset", pin_oe, 8'h00);
      chk("R7 sda reset", {7'b0, sda_low}, 8'h00);
      rst_n = 1'b1;
      tick(4);
      cmp_en = 1'b1;
      rd_reg(2, 1, "R7 pol reset");
      rd_reg(3, 1, "R7 dir reset");

      // R8 direction and output values
      wr_reg(3, 8'h0F);
      wr_reg(1, 8'hA5);
      wr_reg(2, 8'h3C);
      chk("R8 oe map", pin_oe, 8'hF0);

      // R6 live pins with polarity, R4 continuation
      pins = 8'h5A; tick(4);
      rd_reg(0, 3, "R6 input view");
      pins = 8'h81; tick(4);
      rd_reg(0, 2, "R6 input view live");
      rd_reg(1, 2, "R4 out readback");
      rd_reg(3, 1, "R3 dir readback");

      // R9 read without a new command uses the last pointer (3)
      cmp_en = 1'b0;
      bus_start;
      put_byte({ADDR, 1'b1}, a); chk("R9 addr ack", {7'b0, a}, 8'h01);
      get_byte(1'b1, v); chk("R9 last ptr", v, m_dir);
      // R5 master NACK then further bytes ignored
      get_byte(1'b0, v); chk("R4 second byte", v, m_dir);
      put_byte(8'h00, a); chk("R5 ignored ack", {7'b0, a}, 8'h00);
      put_byte(8'h55, a); chk("R5 ignored ack2", {7'b0, a}, 8'h00);
      bus_stop;
      tick(2);
      cmp_en = 1'b1;

      // R6 write to input register discarded
      cmp_en = 1'b0;
      bus_start;
      put_byte({ADDR, 1'b0}, a); chk("R1 addr ack", {7'b0, a}, 8'h01);
      put_byte(8'h00, a);        chk("R2 cmd ack", {7'b0, a}, 8'h01);
      put_byte(8'h00, a);        chk("R2 in-reg data ack", {7'b0, a}, 8'h01);
      bus_stop;
      tick(2);
      cmp_en = 1'b1;
      rd_reg(0, 1, "R6 input after write");
      rd_reg(2, 1, "R6 pol unchanged");

      // R3 multi-byte write lands in one register; upper command bits ignored
      cmp_en = 1'b0;
      bus_start;
      put_byte({ADDR, 1'b0}, a); chk("R1 addr ack", {7'b0, a}, 8'h01);
      put_byte(8'hF1, a);        chk("R2 cmd ack", {7'b0, a}, 8'h01);
      put_byte(8'h11, a);        chk("R2 data ack 1", {7'b0, a}, 8'h01);
      put_byte(8'h22, a);        chk("R2 data ack 2", {7'b0, a}, 8'h01);
      bus_stop;
      m_out = 8'h22;
      tick(2);
      cmp_en = 1'b1;
      chk("R3 out last byte", pin_out, 8'h22);
      rd_reg(1, 1, "R3 out readback");

      // R10 address mismatch, then a new START with the right address
      cmp_en = 1'b0;
      bus_start;
      put_byte({ADDR ^ 7'h01, 1'b0}, a); chk("R10 no ack", {7'b0, a}, 8'h00);
      put_byte(8'h01, a);                chk("R10 ignored cmd", {7'b0, a}, 8'h00);
      put_byte(8'h00, a);                chk("R10 ignored data", {7'b0, a}, 8'h00);
      chk("R10 out kept", pin_out, m_out);
      bus_start;
      put_byte({ADDR, 1'b0}, a); chk("R10 restart ack", {7'b0, a}, 8'h01);
      put_byte(8'h01, a);        chk("R2 cmd ack", {7'b0, a}, 8'h01);
      put_byte(8'h96, a);        chk("R2 data ack", {7'b0, a}, 8'h01);
      bus_stop;
      m_out = 8'h96;
      tick(2);
      cmp_en = 1'b1;
      chk("R8 out after restart", pin_out, 8'h96);
      tick(10);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule